// File: doc/BRIEF.md
# Two-Register Byte Processor Core

This block is a compact 8-bit processor with exactly two data registers. It fetches byte-wide instructions from a synchronous program memory and reads and writes a synchronous data RAM. It moves data to and from the outside world through two 8-bit input ports and two 8-bit output ports. Most instructions occupy one byte. Jump, call, load and store carry a second byte that widens their address. With it, jump and call reach all 4096 bytes of program space, and load and store reach 2048 bytes of data space.

Control flow has four forms. A conditional skip moves forward over one to four bytes. A one-byte branch moves backward by one to sixteen bytes, which closes short loops. Jump and call take a full 12-bit target, and a small circular return stack serves calls and returns. The only arithmetic is a multiply. It always takes the product of the two registers and splits the 16-bit result across both of them. The multiply instruction chooses which register receives the upper byte.

Both memories return data one clock after the address is presented. Each instruction therefore runs as a short sequence of phases: fetch, decode, then an address phase, an execute phase and, for loads, a read phase.

Top module: `tworeg_core`

## Requirements
- R1: While rst_n is low, both registers, both output ports, the PC and the return stack are cleared, imem_addr reads 0 and dmem_we is 0.
- R2: Byte `001r nnnn` loads register r with the 4-bit value nnnn, sign-extended to 8 bits.
- R3: Byte `1100 d s xx` loads register d from in_b when s=1 and from in_a when s=0.
- R4: Byte `1101 d s xx` copies register d to out_b when s=1 and to out_a when s=0. The other output port keeps its value, and an output port changes only when such an instruction commits.
- R5: Byte `1110 d xxx` forms R0×R1 as an unsigned 16-bit product. It writes the upper byte to register d and the lower byte to the other register.
- R6: Byte `0000 r c kk` is a skip. When (register r equals 0) differs from c, the PC advances by kk+2, which passes over kk+1 bytes. Otherwise the PC advances by 1.
- R7: Byte `0001 nnnn` sets the PC to its own address minus (nnnn+1), a backward move of 1 to 16 bytes.
- R8: Bytes `0100 tttt`, `TTTTTTTT` jump to the 12-bit address {tttt, TTTTTTTT}. Bit 4 of the first byte is ignored.
- R9: Bytes `0110 tttt`, `TTTTTTTT` call {tttt, TTTTTTTT}. The call pushes its own address plus 2 onto a 4-entry return stack. A fifth unreturned call overwrites the oldest entry.
- R10: Byte `1111 xxxx` returns. It pops the most recently pushed address into the PC, and its low four bits are ignored.
- R11: Bytes `100r aaaa`, `AAAAAAAA` load register r from data address {bits 2:0 of the first byte, AAAAAAAA}. The instruction takes 5 cycles.
- R12: Bytes `101r aaaa`, `AAAAAAAA` store register r to the same 11-bit address form. dmem_we is high for exactly one cycle, the fourth cycle of the instruction.
- R13: One-byte instructions take 2 cycles, and jump, call and store take 4. imem_addr shows the instruction address during the first two cycles of an instruction and that address plus 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 12 | Program memory byte address |
| imem_rdata | input | 8 | Program memory data, one cycle after address |
| dmem_addr | output | 11 | Data RAM address |
| dmem_wdata | output | 8 | Data RAM write data |
| dmem_we | output | 1 | Data RAM write strobe |
| dmem_rdata | input | 8 | Data RAM read data, one cycle after address |
| in_a | input | 8 | Input port selected by s=0 |
| in_b | input | 8 | Input port selected by s=1 |
| out_a | output | 8 | Output port written with s=0 |
| out_b | output | 8 | Output port written with s=1 |

## Verification
Two situations are hard to reach from the ports. The first is overflow of the return stack. Only a program that nests five calls without returning overwrites the oldest return address, so the stimulus builds exactly such a chain and shows that the outer caller is never resumed. The second is a loop that exits only through a skip. The core has no adder, so nothing in the registers can end such a loop. The stimulus therefore holds an input port at zero while a skip-and-branch-back loop spins, then changes the port mid-run so that the skip is taken and the loop exits. A behavioural model compares the fetch address, both output ports and every store on every cycle.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int DW  = 8;
    localparam int PCW = 12;
    localparam int DAW = 11;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_DEC   = 3'd1,
        ST_ADDR  = 3'd2,
        ST_EXT   = 3'd3,
        ST_LOAD  = 3'd4
    } phase_e;

    typedef enum logic [3:0] {
        OP_SKIP, OP_BRB, OP_LDI, OP_JMP, OP_CALL, OP_LD,
        OP_ST, OP_IN, OP_OUT, OP_MUL, OP_RET
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       r;
        logic       sel;
        logic [3:0] imm;
    } dec_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [DW-1:0] instr,
    output dec_t          dec
);

    always_comb begin
        dec.op  = OP_RET;
        dec.r   = 1'b0;
        dec.sel = 1'b0;
        dec.imm = instr[3:0];
        casez (instr)
            8'b0000_????: begin
                dec.op  = OP_SKIP;
                dec.r   = instr[3];
                dec.sel = instr[2];
                dec.imm = {2'b00, instr[1:0]};
            end
            8'b0001_????: dec.op = OP_BRB;
            8'b001?_????: begin
                dec.op = OP_LDI;
                dec.r  = instr[4];
            end
            8'b01??_????: dec.op = instr[5] ? OP_CALL : OP_JMP;
            8'b10??_????: begin
                dec.op  = instr[5] ? OP_ST : OP_LD;
                dec.r   = instr[4];
                dec.imm = {1'b0, instr[2:0]};
            end
            8'b1100_????: begin
                dec.op  = OP_IN;
                dec.r   = instr[3];
                dec.sel = instr[2];
            end
            8'b1101_????: begin
                dec.op  = OP_OUT;
                dec.r   = instr[3];
                dec.sel = instr[2];
            end
            8'b1110_????: begin
                dec.op = OP_MUL;
                dec.r  = instr[3];
            end
            default: dec.op = OP_RET;
        endcase
    end

endmodule

// File: rtl/core_retstack.sv
module core_retstack #(
    parameter int DEPTH = 4,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0]         ptr;
        logic [DEPTH-1:0][W-1:0] ent;
    } rs_t;

    rs_t st_d, st_q;
    logic [PW-1:0] ptr_inc, ptr_dec;

    always_comb begin
        ptr_inc = (st_q.ptr == LAST) ? '0 : st_q.ptr + PW'(1);
        ptr_dec = (st_q.ptr == '0) ? LAST : st_q.ptr - PW'(1);
        top_val = st_q.ent[ptr_dec];
        st_d    = st_q;
        if (push) begin
            st_d.ent[st_q.ptr] = push_val;
            st_d.ptr           = ptr_inc;
        end else if (pop) begin
            st_d.ptr = ptr_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/core_mul.sv
module core_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);

    logic [W-1:0][2*W-1:0] pp;

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < W; i++) prod = prod + pp[i];
    end

endmodule

// File: rtl/tworeg_core.sv
module tworeg_core
    import core_pkg::*;
#(
    parameter int RS_DEPTH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PCW-1:0] imem_addr,
    input  logic [DW-1:0]  imem_rdata,
    output logic [DAW-1:0] dmem_addr,
    output logic [DW-1:0]  dmem_wdata,
    output logic           dmem_we,
    input  logic [DW-1:0]  dmem_rdata,
    input  logic [DW-1:0]  in_a,
    input  logic [DW-1:0]  in_b,
    output logic [DW-1:0]  out_a,
    output logic [DW-1:0]  out_b
);

    typedef struct packed {
        phase_e               ph;
        logic [PCW-1:0]       pc;
        logic [1:0][DW-1:0]   rg;
        logic [DW-1:0]        oa;
        logic [DW-1:0]        ob;
        logic [DW-1:0]        ir;
    } core_t;

    core_t cur_d, cur_q;

    logic [DW-1:0]   dec_in;
    dec_t            dec;
    logic [2*DW-1:0] prod;
    logic            rs_push, rs_pop;
    logic [PCW-1:0]  rs_push_val, rs_top;
    logic            dec_phase;
    logic [DW-1:0]   reg0_w, reg1_w;

    assign dec_in    = (cur_q.ph == ST_DEC) ? imem_rdata : cur_q.ir;
    assign dec_phase = (cur_q.ph == ST_DEC);
    assign reg0_w    = cur_q.rg[0];
    assign reg1_w    = cur_q.rg[1];

    core_decode u_dec (
        .instr (dec_in),
        .dec   (dec)
    );

    core_mul #(.W(DW)) u_mul (
        .a    (cur_q.rg[0]),
        .b    (cur_q.rg[1]),
        .prod (prod)
    );

    core_retstack #(.DEPTH(RS_DEPTH), .W(PCW)) u_rs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rs_push),
        .pop      (rs_pop),
        .push_val (rs_push_val),
        .top_val  (rs_top)
    );

    assign imem_addr = (cur_q.ph == ST_FETCH || cur_q.ph == ST_DEC)
                       ? cur_q.pc : cur_q.pc + PCW'(1);
    assign out_a     = cur_q.oa;
    assign out_b     = cur_q.ob;

    always_comb begin
        cur_d       = cur_q;
        rs_push     = 1'b0;
        rs_pop      = 1'b0;
        rs_push_val = cur_q.pc + PCW'(2);
        dmem_we     = 1'b0;
        dmem_addr   = {cur_q.ir[2:0], imem_rdata};
        dmem_wdata  = cur_q.rg[cur_q.ir[4]];
        case (cur_q.ph)
            ST_FETCH: cur_d.ph = ST_DEC;
            ST_DEC: begin
                cur_d.ir = imem_rdata;
                cur_d.ph = ST_FETCH;
                cur_d.pc = cur_q.pc + PCW'(1);
                case (dec.op)
                    OP_SKIP: begin
                        if ((cur_q.rg[dec.r] == '0) != dec.sel)
                            cur_d.pc = cur_q.pc + PCW'(2) + PCW'(dec.imm);
                    end
                    OP_BRB:  cur_d.pc = cur_q.pc - (PCW'(dec.imm) + PCW'(1));
                    OP_LDI:  cur_d.rg[dec.r] = {{(DW-4){dec.imm[3]}}, dec.imm};
                    OP_IN:   cur_d.rg[dec.r] = dec.sel ? in_b : in_a;
                    OP_OUT: begin
                        if (dec.sel) cur_d.ob = cur_q.rg[dec.r];
                        else         cur_d.oa = cur_q.rg[dec.r];
                    end
                    OP_MUL: begin
                        cur_d.rg[dec.r]  = prod[2*DW-1:DW];
                        cur_d.rg[~dec.r] = prod[DW-1:0];
                    end
                    OP_RET: begin
                        rs_pop   = 1'b1;
                        cur_d.pc = rs_top;
                    end
                    default: begin
                        cur_d.ph = ST_ADDR;
                        cur_d.pc = cur_q.pc;
                    end
                endcase
            end
            ST_ADDR: cur_d.ph = ST_EXT;
            ST_EXT: begin
                cur_d.ph = ST_FETCH;
                cur_d.pc = cur_q.pc + PCW'(2);
                case (dec.op)
                    OP_JMP:  cur_d.pc = {dec.imm, imem_rdata};
                    OP_CALL: begin
                        rs_push  = 1'b1;
                        cur_d.pc = {dec.imm, imem_rdata};
                    end
                    OP_ST:   dmem_we = 1'b1;
                    OP_LD: begin
                        cur_d.ph = ST_LOAD;
                        cur_d.pc = cur_q.pc;
                    end
                    default: ;
                endcase
            end
            ST_LOAD: begin
                cur_d.rg[cur_q.ir[4]] = dmem_rdata;
                cur_d.pc              = cur_q.pc + PCW'(2);
                cur_d.ph              = ST_FETCH;
            end
            default: cur_d.ph = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

endmodule

// File: rtl/core_checker.sv
module core_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_dec,
    input logic [7:0]  instr,
    input logic [11:0] imem_addr,
    input logic        dmem_we,
    input logic [7:0]  out_a,
    input logic [7:0]  out_b,
    input logic [7:0]  r0,
    input logic [7:0]  r1
);

    assert_store_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_a) |-> $stable(out_b));

    assert_mul_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dec && instr[7:4] == 4'hE) |=>
        (($past(instr[3]) ? {r1, r0} : {r0, r1}) == 16'($past(r0) * $past(r1))));

    assert_skip_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dec && instr[7:4] == 4'h0) |=>
        (12'(imem_addr - $past(imem_addr)) >= 12'd1 &&
         12'(imem_addr - $past(imem_addr)) <= 12'd5));

    assert_branch_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dec && instr[7:4] == 4'h1) |=>
        (12'($past(imem_addr) - imem_addr) >= 12'd1 &&
         12'($past(imem_addr) - imem_addr) <= 12'd16));

endmodule

bind tworeg_core core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_dec    (dec_phase),
    .instr     (imem_rdata),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .out_a     (out_a),
    .out_b     (out_b),
    .r0        (reg0_w),
    .r1        (reg1_w)
);

// File: tb/test_tworeg_core.sv
module test_tworeg_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] imem_addr;
    logic [7:0]  imem_rdata;
    logic [10:0] dmem_addr;
    logic [7:0]  dmem_wdata;
    logic        dmem_we;
    logic [7:0]  dmem_rdata;
    logic [7:0]  in_a = 8'h00;
    logic [7:0]  in_b = 8'h00;
    logic [7:0]  out_a, out_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [7:0] imem [256];
    logic [7:0] dmem [2048];

    always #5 clk = ~clk;

    tworeg_core i_tworeg_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .in_a(in_a), .in_b(in_b),
        .out_a(out_a), .out_b(out_b)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[7:0]];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired, got cycle %0d expected below 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // behavioural reference model
    int         m_pc, m_k, m_len, m_sp;
    logic [7:0] m_r [2];
    logic [7:0] m_oa, m_ob, m_b, m_e;
    int         m_stk [4];
    logic [7:0] m_ram [2048];
    string      m_tag, m_last;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int got, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_k = 0; m_sp = 0;
        m_r[0] = 8'h00; m_r[1] = 8'h00; m_oa = 8'h00; m_ob = 8'h00;
        m_last = "R1";
        for (int i = 0; i < 4; i++) m_stk[i] = 0;
    endtask

    task automatic model_commit();
        logic [15:0] p;
        int t;
        t = {m_b[3:0], m_e};
        case (m_b[7:6])
            2'b00: begin
                if (m_b[5]) begin
                    m_r[m_b[4]] = {{4{m_b[3]}}, m_b[3:0]};
                    m_pc = m_pc + 1;
                end else if (m_b[4]) begin
                    m_pc = m_pc - (m_b[3:0] + 1);
                end else if ((m_r[m_b[3]] == 8'h00) != m_b[2]) begin
                    m_pc = m_pc + m_b[1:0] + 2;
                end else begin
                    m_pc = m_pc + 1;
                end
            end
            2'b01: begin
                if (m_b[5]) begin
                    m_stk[m_sp] = (m_pc + 2) & 12'hFFF;
                    m_sp = (m_sp + 1) % 4;
                end
                m_pc = t;
            end
            2'b10: begin
                if (m_b[5]) m_ram[{m_b[2:0], m_e}] = m_r[m_b[4]];
                else        m_r[m_b[4]] = m_ram[{m_b[2:0], m_e}];
                m_pc = m_pc + 2;
            end
            default: begin
                m_pc = m_pc + 1;
                case (m_b[5:4])
                    2'b00: m_r[m_b[3]] = m_b[2] ? in_b : in_a;
                    2'b01: if (m_b[2]) m_ob = m_r[m_b[3]]; else m_oa = m_r[m_b[3]];
                    2'b10: begin
                        p = m_r[0] * m_r[1];
                        m_r[m_b[3]]  = p[15:8];
                        m_r[!m_b[3]] = p[7:0];
                    end
                    default: begin
                        m_sp = (m_sp + 3) % 4;
                        m_pc = m_stk[m_sp];
                    end
                endcase
            end
        endcase
        m_pc = m_pc & 12'hFFF;
        m_last = m_tag;
    endtask

    task automatic model_step();
        int ea;
        bit st;
        if (m_k == 0) begin
            m_b = imem[m_pc[7:0]];
            m_e = imem[(m_pc + 1) & 8'hFF];
            case (m_b[7:6])
                2'b00: begin m_len = 2; m_tag = m_b[5] ? "R2" : (m_b[4] ? "R7" : "R6"); end
                2'b01: begin m_len = 4; m_tag = m_b[5] ? "R9" : "R8"; end
                2'b10: begin m_len = m_b[5] ? 4 : 5; m_tag = m_b[5] ? "R12" : "R11"; end
                default: begin
                    m_len = 2;
                    case (m_b[5:4])
                        2'b00: m_tag = "R3";
                        2'b01: m_tag = "R4";
                        2'b10: m_tag = "R5";
                        default: m_tag = "R10";
                    endcase
                end
            endcase
        end
        ea = (m_k < 2) ? m_pc : ((m_pc + 1) & 12'hFFF);
        chk(imem_addr == ea, m_tag, "R13 fetch address", imem_addr, ea);
        chk(out_a == m_oa, m_last, "out_a", out_a, m_oa);
        chk(out_b == m_ob, m_last, "out_b", out_b, m_ob);
        st = (m_b[7:5] == 3'b101) && (m_k == 3);
        chk(dmem_we == st, "R12", "dmem_we", dmem_we, st);
        if (st) begin
            chk(dmem_addr == {m_b[2:0], m_e}, "R12", "dmem_addr", dmem_addr, {m_b[2:0], m_e});
            chk(dmem_wdata == m_r[m_b[4]], "R12", "dmem_wdata", dmem_wdata, m_r[m_b[4]]);
        end
        m_k = m_k + 1;
        if (m_k == m_len) begin
            model_commit();
            m_k = 0;
        end
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) imem[i] = 8'h00;
        for (int i = 0; i < 2048; i++) begin
            dmem[i]  = 8'(i * 7);
            m_ram[i] = 8'(i * 7);
        end
    endtask

    task automatic release_reset();
        repeat (3) @(negedge clk);
        chk(imem_addr == 12'h000, "R1", "reset imem_addr", imem_addr, 0);
        chk(out_a == 8'h00, "R1", "reset out_a", out_a, 0);
        chk(out_b == 8'h00, "R1", "reset out_b", out_b, 0);
        chk(dmem_we == 1'b0, "R1", "reset dmem_we", dmem_we, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic put(input int a, input logic [7:0] v);
        imem[a] = v;
    endtask

    initial begin
        // program 1: immediates, ports and multiply (R2 R3 R4 R5)
        start_prog();
        in_b = 8'h5A;
        put(0, 8'h23); put(1, 8'h3E); put(2, 8'hD0); put(3, 8'hDC);
        put(4, 8'hE0); put(5, 8'hD0); put(6, 8'hDC); put(7, 8'hE8);
        put(8, 8'hD0); put(9, 8'hDC); put(10, 8'hC4); put(11, 8'hD4);
        put(12, 8'h40); put(13, 8'h0C);
        release_reset();
        run(9);
        chk(out_b == 8'hFE, "R2", "sign-extended -2 on out_b", out_b, 8'hFE);
        run(6);
        chk(out_a == 8'h02, "R5", "mul high byte in d=0", out_a, 8'h02);
        run(4);
        chk(out_b == 8'hFA, "R5", "mul low byte in other", out_b, 8'hFA);
        run(30);
        chk(out_a == 8'hF4, "R5", "mul d=1 low byte", out_a, 8'hF4);
        chk(out_b == 8'h5A, "R3", "input port b value", out_b, 8'h5A);

        // program 2: skips and a loop closed by a backward branch (R6 R7)
        start_prog();
        in_a = 8'h00;
        put(0, 8'h20); put(1, 8'h01); put(2, 8'h21); put(3, 8'h22);
        put(4, 8'h3F); put(5, 8'h0F);
        for (int i = 6; i < 10; i++) put(i, 8'h27);
        put(10, 8'hD0); put(11, 8'hC0); put(12, 8'h04); put(13, 8'h11);
        put(14, 8'h08); put(15, 8'hD4); put(16, 8'h40); put(17, 8'h10);
        release_reset();
        run(40);
        chk(out_a == 8'h00, "R6", "skips passed over loads", out_a, 8'h00);
        chk(out_b == 8'h00, "R7", "loop still spinning", out_b, 8'h00);
        in_a = 8'h33;
        run(40);
        chk(out_b == 8'h33, "R6", "loop exit through skip", out_b, 8'h33);

        // program 3: call and return, ignored low bits of return (R9 R10)
        start_prog();
        put(0, 8'h60); put(1, 8'h20); put(2, 8'hD0); put(3, 8'h40); put(4, 8'h03);
        put(8'h20, 8'h25); put(8'h21, 8'h60); put(8'h22, 8'h30); put(8'h23, 8'hF0);
        put(8'h30, 8'h35); put(8'h31, 8'hDC); put(8'h32, 8'hF7);
        release_reset();
        run(60);
        chk(out_a == 8'h05, "R10", "nested returns reach caller", out_a, 8'h05);
        chk(out_b == 8'h05, "R9", "inner call ran", out_b, 8'h05);

        // program 4: five nested calls wrap the return stack (R9)
        start_prog();
        put(0, 8'h60); put(1, 8'h10); put(2, 8'hD0); put(3, 8'h40); put(4, 8'h03);
        put(8'h10, 8'h60); put(8'h11, 8'h18); put(8'h12, 8'hF0);
        put(8'h18, 8'h60); put(8'h19, 8'h20); put(8'h1A, 8'hF0);
        put(8'h20, 8'h60); put(8'h21, 8'h28); put(8'h22, 8'hF0);
        put(8'h28, 8'h60); put(8'h29, 8'h30); put(8'h2A, 8'hF0);
        put(8'h30, 8'h23); put(8'h31, 8'hF0);
        release_reset();
        run(120);
        chk(out_a == 8'h00, "R9", "outer caller lost after wrap", out_a, 8'h00);

        // program 5: 16-byte branch back, stores and loads (R7 R8 R11 R12)
        start_prog();
        put(0, 8'h50); put(1, 8'h20);
        put(8'h10, 8'h31); put(8'h11, 8'hDC); put(8'h12, 8'h24);
        put(8'h13, 8'hA1); put(8'h14, 8'h23); put(8'h15, 8'h20); put(8'h16, 8'h3C);
        put(8'h17, 8'hBF); put(8'h18, 8'hFF); put(8'h19, 8'h91); put(8'h1A, 8'h23);
        put(8'h1B, 8'h87); put(8'h1C, 8'hFF); put(8'h1D, 8'hD0); put(8'h1E, 8'hDC);
        put(8'h1F, 8'h40); put(8'h20, 8'h1F);
        release_reset();
        run(12);
        chk(out_b == 8'h01, "R7", "branch back by 16 reached target", out_b, 8'h01);
        run(60);
        chk(dmem[11'h123] == 8'h04, "R12", "stored byte at 0x123", dmem[11'h123], 8'h04);
        chk(dmem[11'h7FF] == 8'hFC, "R12", "stored byte at 0x7FF", dmem[11'h7FF], 8'hFC);
        chk(out_a == 8'hFC, "R11", "load from top address", out_a, 8'hFC);
        chk(out_b == 8'h04, "R11", "load into r1", out_b, 8'h04);
        chk(imem_addr == 12'h01F || imem_addr == 12'h020, "R8", "parked on jump", imem_addr, 12'h01F);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule